// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block measures how long a processor keeps its interrupt mask bits set. It watches two mask bits: the ordinary interrupt mask and the non-maskable-request mask. Each is sampled only when an instruction-boundary strobe is high, and each is timed against a free-running 64-bit cycle count that the block receives as an input.

Each bit has its own tracker, and the two trackers behave the same way. When a masked interval ends, the tracker records its length and uses it to update the shortest, longest and most recent interval. While an interval is still open, the tracker reports its running length. A designer or a debug path reads these figures to find code that holds interrupts off for too long. Turning the figures into time units is left to the reader.

Top module: `imask_monitor`

## Requirements
- R1: On a clock edge where `smp_vld` is 1, the mask bit is 1 and no interval is open, the tracker latches `cyc_cnt` as the start of the interval, and the open flag reads 1 after that edge.
- R2: On a clock edge where `smp_vld` is 1, the mask bit is 0 and an interval is open, the duration is `cyc_cnt` minus the latched start. After that edge the last output equals this duration and the open flag reads 0.
- R3: When an interval closes, the max output becomes the larger of the old max and the duration.
- R4: When an interval closes, the stored min becomes the smaller of the old stored min and the duration. The min output shows the stored min. While the stored min still holds its initial value of 2^62−1, the min output shows the max output instead.
- R5: After synchronous active-high reset, the open flag, max, last, min output and current output all read 0, and the stored min holds 2^62−1.
- R6: The current output is combinational. While an interval is open it equals the live `cyc_cnt` minus the start. While no interval is open it is 0.
- R7: On a clock edge where `smp_vld` is 0, no state changes, whatever the mask bits and the cycle count are.
- R8: Durations saturate at 2^62−1. This happens when the difference exceeds that value and also when `cyc_cnt` is below the latched start.
- R9: The `ccr_i` tracker drives only the `i_*` outputs and the `ccr_x` tracker drives only the `x_*` outputs. Neither tracker affects the other.
- R10: On a clock edge where `smp_vld` is 1, the mask bit is 1 and an interval is open, the interval stays open with its original start. If the live duration is larger than max, max takes the live duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Instruction-boundary sample strobe |
| ccr_i | input | 1 | Interrupt mask bit |
| ccr_x | input | 1 | Non-maskable-request mask bit |
| cyc_cnt | input | 64 | Free-running cycle count |
| i_min | output | 62 | Shortest completed interval of the I mask (falls back to max) |
| i_max | output | 62 | Longest interval of the I mask |
| i_last | output | 62 | Most recent completed interval of the I mask |
| i_cur | output | 62 | Running length of the open I interval, 0 if none |
| i_open | output | 1 | I-mask interval open |
| x_min | output | 62 | Shortest completed interval of the X mask (falls back to max) |
| x_max | output | 62 | Longest interval of the X mask |
| x_last | output | 62 | Most recent completed interval of the X mask |
| x_cur | output | 62 | Running length of the open X interval, 0 if none |
| x_open | output | 1 | X-mask interval open |

## Verification
Directed sequences cover five cases:
- An isolated interval, which confirms the basic open, close and subtraction path.
- A longer interval followed by a shorter one, which separates the update of min from the update of max.
- Mask toggles with the strobe low, which show that unstrobed samples are ignored.
- A strobe that repeats a set mask bit, which tells the live-max raise apart from re-latching the start.
- A backwards cycle count and a very large gap, which both exercise saturation.

Random traffic then drives the two mask bits with different patterns. Mismatched open and close times show whether either tracker leaks into the other. The random cycle steps land intervals of many lengths against the running min and max.

// File: rtl/imask_pkg.sv
package imask_pkg;

    localparam int CNT_W = 64;
    localparam int DUR_W = 62;
    localparam int NUM_MASKS = 2;

    typedef struct packed {
        logic [DUR_W-1:0] lo;
        logic [DUR_W-1:0] hi;
        logic [DUR_W-1:0] last;
    } dur_stats_t;

    function automatic logic [DUR_W-1:0] dur_min(input logic [DUR_W-1:0] a,
                                                 input logic [DUR_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [DUR_W-1:0] dur_max(input logic [DUR_W-1:0] a,
                                                 input logic [DUR_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/imask_dur_calc.sv
module imask_dur_calc #(
    parameter int CNT_W = imask_pkg::CNT_W,
    parameter int DUR_W = imask_pkg::DUR_W
) (
    input  logic [CNT_W-1:0] now_cyc,
    input  logic [CNT_W-1:0] start_cyc,
    output logic [DUR_W-1:0] dur
);
    localparam logic [CNT_W-1:0] LIMIT = {{(CNT_W-DUR_W){1'b0}}, {DUR_W{1'b1}}};

    logic [CNT_W-1:0] diff;

    always_comb begin
        diff = now_cyc - start_cyc;
        if (now_cyc < start_cyc || diff > LIMIT)
            dur = {DUR_W{1'b1}};
        else
            dur = diff[DUR_W-1:0];
    end
endmodule

// File: rtl/imask_tracker.sv
module imask_tracker
    import imask_pkg::*;
#(
    parameter int TCNT_W = CNT_W,
    parameter int TDUR_W = DUR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic              mask_bit,
    input  logic [TCNT_W-1:0] cyc_now,
    output logic [TDUR_W-1:0] min_rep,
    output logic [TDUR_W-1:0] max_dur,
    output logic [TDUR_W-1:0] last_dur,
    output logic [TDUR_W-1:0] cur_dur,
    output logic              is_open
);
    localparam logic [TDUR_W-1:0] MIN_INIT = {TDUR_W{1'b1}};

    typedef enum logic [1:0] {
        EV_NONE,
        EV_OPEN,
        EV_HOLD,
        EV_CLOSE
    } trk_ev_e;

    logic              open_q;
    logic [TCNT_W-1:0] start_q;
    logic [TDUR_W-1:0] lo_q, hi_q, last_q;
    logic [TDUR_W-1:0] live_dur;
    trk_ev_e           ev;

    imask_dur_calc #(.CNT_W(TCNT_W), .DUR_W(TDUR_W)) u_calc (
        .now_cyc  (cyc_now),
        .start_cyc(start_q),
        .dur      (live_dur)
    );

    always_comb begin
        ev = EV_NONE;
        if (smp_vld) begin
            if (mask_bit && !open_q)      ev = EV_OPEN;
            else if (mask_bit && open_q)  ev = EV_HOLD;
            else if (!mask_bit && open_q) ev = EV_CLOSE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            start_q <= '1;
            lo_q    <= MIN_INIT;
            hi_q    <= '0;
            last_q  <= '0;
        end else begin
            unique case (ev)
                EV_OPEN: begin
                    open_q  <= 1'b1;
                    start_q <= cyc_now;
                end
                EV_HOLD: begin
                    hi_q <= dur_max(hi_q, live_dur);
                end
                EV_CLOSE: begin
                    open_q  <= 1'b0;
                    start_q <= '1;
                    lo_q    <= dur_min(lo_q, live_dur);
                    hi_q    <= dur_max(hi_q, live_dur);
                    last_q  <= live_dur;
                end
                default: ;
            endcase
        end
    end

    assign min_rep  = (lo_q == MIN_INIT) ? hi_q : lo_q;
    assign max_dur  = hi_q;
    assign last_dur = last_q;
    assign cur_dur  = open_q ? live_dur : '0;
    assign is_open  = open_q;
endmodule

// File: rtl/imask_monitor.sv
module imask_monitor
    import imask_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             ccr_i,
    input  logic             ccr_x,
    input  logic [CNT_W-1:0] cyc_cnt,
    output logic [DUR_W-1:0] i_min,
    output logic [DUR_W-1:0] i_max,
    output logic [DUR_W-1:0] i_last,
    output logic [DUR_W-1:0] i_cur,
    output logic             i_open,
    output logic [DUR_W-1:0] x_min,
    output logic [DUR_W-1:0] x_max,
    output logic [DUR_W-1:0] x_last,
    output logic [DUR_W-1:0] x_cur,
    output logic             x_open
);
    logic [NUM_MASKS-1:0] mask_vec;
    logic [DUR_W-1:0]     min_a  [NUM_MASKS];
    logic [DUR_W-1:0]     max_a  [NUM_MASKS];
    logic [DUR_W-1:0]     last_a [NUM_MASKS];
    logic [DUR_W-1:0]     cur_a  [NUM_MASKS];
    logic [NUM_MASKS-1:0] open_a;

    assign mask_vec = {ccr_x, ccr_i};

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_trk
        imask_tracker u_trk (
            .clk     (clk),
            .rst     (rst),
            .smp_vld (smp_vld),
            .mask_bit(mask_vec[g]),
            .cyc_now (cyc_cnt),
            .min_rep (min_a[g]),
            .max_dur (max_a[g]),
            .last_dur(last_a[g]),
            .cur_dur (cur_a[g]),
            .is_open (open_a[g])
        );
    end

    assign i_min  = min_a[0];
    assign i_max  = max_a[0];
    assign i_last = last_a[0];
    assign i_cur  = cur_a[0];
    assign i_open = open_a[0];
    assign x_min  = min_a[1];
    assign x_max  = max_a[1];
    assign x_last = last_a[1];
    assign x_cur  = cur_a[1];
    assign x_open = open_a[1];
endmodule

// File: rtl/imask_monitor_chk.sv
module imask_monitor_chk
    import imask_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             mask,
    input logic [DUR_W-1:0] min_d,
    input logic [DUR_W-1:0] max_d,
    input logic [DUR_W-1:0] last_d,
    input logic [DUR_W-1:0] cur_d,
    input logic             open_d
);
    AST_OPEN_ON_MASK: assert property (@(posedge clk) disable iff (rst)
        smp_vld && mask && !open_d |=> open_d); // R1

    AST_CLOSE_ON_UNMASK: assert property (@(posedge clk) disable iff (rst)
        smp_vld && !mask && open_d |=> !open_d); // R2

    AST_LAST_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
        last_d <= max_d); // R3

    AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
        min_d <= max_d); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!open_d && max_d == '0 && last_d == '0 && min_d == '0)); // R5

    AST_CUR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !open_d |-> cur_d == '0); // R6

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(open_d) && $stable(max_d) && $stable(last_d) && $stable(min_d))); // R7

    AST_HOLD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
        smp_vld && mask && open_d |=> open_d && max_d >= $past(max_d)); // R10
endmodule

bind imask_monitor imask_monitor_chk u_chk_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .mask(ccr_i),
    .min_d(i_min), .max_d(i_max), .last_d(i_last), .cur_d(i_cur), .open_d(i_open)
);

bind imask_monitor imask_monitor_chk u_chk_x (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .mask(ccr_x),
    .min_d(x_min), .max_d(x_max), .last_d(x_last), .cur_d(x_cur), .open_d(x_open)
);

// File: tb/imask_monitor_tb.sv
`timescale 1ns/1ps
module imask_monitor_tb;
    localparam logic [63:0] DMAX = (64'd1 << 62) - 64'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic        ccr_i = 1'b0;
    logic        ccr_x = 1'b0;
    logic [63:0] cyc_cnt = '0;
    logic [61:0] i_min, i_max, i_last, i_cur, x_min, x_max, x_last, x_cur;
    logic        i_open, x_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_open [2];
    logic [63:0] m_start[2];
    logic [63:0] m_lo   [2];
    logic [63:0] m_hi   [2];
    logic [63:0] m_last [2];

    always #10 clk = ~clk;

    imask_monitor u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .ccr_i(ccr_i), .ccr_x(ccr_x),
        .cyc_cnt(cyc_cnt),
        .i_min(i_min), .i_max(i_max), .i_last(i_last), .i_cur(i_cur), .i_open(i_open),
        .x_min(x_min), .x_max(x_max), .x_last(x_last), .x_cur(x_cur), .x_open(x_open)
    );

    function automatic logic [63:0] sat_dur(input logic [63:0] now, input logic [63:0] st);
        if (now < st) return DMAX;
        if (now - st > DMAX) return DMAX;
        return now - st;
    endfunction

    function automatic logic [63:0] umax(input logic [63:0] a, input logic [63:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [63:0] umin(input logic [63:0] a, input logic [63:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [63:0] exp_min(input int k);
        return (m_lo[k] == DMAX) ? m_hi[k] : m_lo[k];
    endfunction

    function automatic logic [63:0] exp_cur(input int k);
        return m_open[k] ? sat_dur(cyc_cnt, m_start[k]) : 64'd0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_open[k] = 1'b0; m_start[k] = '1; m_lo[k] = DMAX;
            m_hi[k] = '0; m_last[k] = '0;
        end
    endtask

    task automatic model_step(input int k, input logic s, input logic m);
        logic [63:0] d;
        d = sat_dur(cyc_cnt, m_start[k]);
        if (!s) return;
        if (m && !m_open[k]) begin
            m_open[k] = 1'b1; m_start[k] = cyc_cnt;
        end else if (m && m_open[k]) begin
            m_hi[k] = umax(m_hi[k], d);
        end else if (!m && m_open[k]) begin
            m_open[k] = 1'b0; m_lo[k] = umin(m_lo[k], d);
            m_hi[k] = umax(m_hi[k], d); m_last[k] = d;
            m_start[k] = '1;
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " i_open"}, {63'd0, i_open}, {63'd0, m_open[0]});
        chk({tag, " i_max"},  {2'b0, i_max},  m_hi[0]);
        chk({tag, " i_last"}, {2'b0, i_last}, m_last[0]);
        chk({tag, " i_min"},  {2'b0, i_min},  exp_min(0));
        chk({tag, " x_open R9"}, {63'd0, x_open}, {63'd0, m_open[1]});
        chk({tag, " x_max R9"},  {2'b0, x_max},  m_hi[1]);
        chk({tag, " x_last R9"}, {2'b0, x_last}, m_last[1]);
        chk({tag, " x_min R9"},  {2'b0, x_min},  exp_min(1));
    endtask

    task automatic step(input logic s, input logic mi, input logic mx,
                        input logic [63:0] cyc, input string tag);
        @(negedge clk);
        smp_vld = s; ccr_i = mi; ccr_x = mx; cyc_cnt = cyc;
        #1;
        chk({tag, " R6 i_cur"}, {2'b0, i_cur}, exp_cur(0));
        chk({tag, " R6 x_cur"}, {2'b0, x_cur}, exp_cur(1));
        model_step(0, s, mi);
        model_step(1, s, mx);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] c;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R5 reset state
        chk("R5 i_open", {63'd0, i_open}, 64'd0);
        chk("R5 i_min", {2'b0, i_min}, 64'd0);
        chk("R5 i_cur", {2'b0, i_cur}, 64'd0);
        check_all("R5");

        // R1 R2 R3 R4: one interval of 30
        step(1, 1, 0, 64'd100, "R1 open");
        step(0, 0, 0, 64'd115, "R7 idle");
        step(1, 0, 0, 64'd130, "R2 close");
        chk("R2 i_last=30", {2'b0, i_last}, 64'd30);
        chk("R4 i_min=30", {2'b0, i_min}, 64'd30);
        // longer then shorter: min vs max
        step(1, 1, 0, 64'd200, "R1 open2");
        step(1, 0, 0, 64'd300, "R3 close long");
        chk("R3 i_max=100", {2'b0, i_max}, 64'd100);
        step(1, 1, 0, 64'd400, "R1 open3");
        step(1, 0, 0, 64'd410, "R4 close short");
        chk("R4 i_min=10", {2'b0, i_min}, 64'd10);
        // R7: toggles without strobe
        step(0, 1, 1, 64'd500, "R7 nostrobe set");
        step(0, 0, 0, 64'd510, "R7 nostrobe clr");
        chk("R7 i_open stays 0", {63'd0, i_open}, 64'd0);
        // R10: hold with live raise
        step(1, 1, 0, 64'd1000, "R10 open");
        step(1, 1, 0, 64'd1500, "R10 hold");
        chk("R10 i_max=500", {2'b0, i_max}, 64'd500);
        step(1, 0, 0, 64'd1520, "R10 close");
        chk("R10 i_last=520", {2'b0, i_last}, 64'd520);
        // R9: X alone
        step(1, 0, 1, 64'd2000, "R9 x open");
        step(1, 0, 0, 64'd2007, "R9 x close");
        chk("R9 x_last=7", {2'b0, x_last}, 64'd7);
        chk("R9 i_last kept", {2'b0, i_last}, 64'd520);
        // R8: backwards count, and huge gap
        step(1, 1, 0, 64'd5000, "R8 open");
        step(1, 0, 0, 64'd4000, "R8 backwards close");
        chk("R8 i_last sat", {2'b0, i_last}, DMAX);
        step(1, 0, 1, 64'd0, "R8 x open");
        step(1, 0, 0, 64'h8000_0000_0000_0000, "R8 huge close");
        chk("R8 x_max sat", {2'b0, x_max}, DMAX);

        // mid-run reset
        @(negedge clk); rst = 1'b1; smp_vld = 1'b0;
        @(posedge clk); #1; @(negedge clk); rst = 1'b0;
        model_reset();
        #1;
        check_all("R5 rerun");

        // random traffic
        c = 64'd10;
        for (int n = 0; n < 3000; n++) begin
            c = c + 64'($urandom_range(1, 20));
            step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0),
                 ($urandom_range(0, 4) == 0), c, "R1 R2 R3 R4 rand");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule